// File: doc/BRIEF.md
# Encoded Integer ALU with Flags

A purely combinational integer arithmetic and logic unit for a processor datapath. Two operand words and a 4-bit operation code enter; a result word, a zero flag and an overflow flag leave in the same cycle. One ripple adder serves every arithmetic code. Addition feeds the second operand straight through. Subtraction and both comparisons invert the second operand and force the carry-in high. The bitwise codes bypass the adder and are picked by the result multiplexer.

Sign or zero extension of immediates, shifts, multiply and divide are done by other blocks. The unit only raises the overflow flag. Any trap or exception on overflow is the job of the surrounding control logic. Equality is tested by subtracting and reading the zero flag.

Top module: `int_alu`

## Requirements
- R1: Codes 0x0 (signed add) and 0x1 (unsigned add) return A+B modulo 2^W.
- R2: Codes 0x2 (signed subtract) and 0x3 (unsigned subtract) return A-B modulo 2^W, formed as A + ~B + 1.
- R3: Codes 0x4, 0x5, 0x6 and 0x7 return bitwise AND, OR, XOR and NOR of A and B.
- R4: For codes 0x0 and 0x2, overflow is high exactly when the two's-complement result does not fit in W bits. This equals the carry into the top bit XOR the carry out of it.
- R5: For every code other than 0x0 and 0x2, overflow is low.
- R6: Code 0xA returns 1 in bit 0 when A < B as signed numbers and 0 otherwise. The result stays correct when A-B overflows, and bits W-1..1 are 0.
- R7: Code 0xB returns 1 in bit 0 when A < B as unsigned numbers (the subtraction has no carry out) and 0 otherwise. Bits W-1..1 are 0.
- R8: For every code, the zero flag is high exactly when all W result bits are 0. With code 0x2 it is therefore high exactly when A equals B.
- R9: The unused codes 0x8, 0x9 and 0xC to 0xF return a result of 0 and overflow 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_code | input | 4 | Operation select |
| opnd_a | input | W (32) | First operand |
| opnd_b | input | W (32) | Second operand |
| res_out | output | W (32) | Selected result |
| flag_zero | output | 1 | High when res_out is all zeros |
| flag_ovf | output | 1 | Signed overflow of add or subtract |

## Verification
The assertions assume the operands and operation code are settled, two-state values whenever the combinational checks evaluate. The unit has no clock of its own to qualify them. The bench applies each vector on a rising edge and compares half a period later, so no check sees a value while it is changing. The stimulus covers all sixteen codes, including the unused ones, against pairs of extreme operands. Those pairs include the most negative and most positive values, 0 and all-ones, which drive every overflow and comparison corner. Random operand pairs are then added.

// File: rtl/int_alu_pkg.sv
package int_alu_pkg;

    typedef enum logic [3:0] {
        OP_ADD  = 4'h0,
        OP_ADDU = 4'h1,
        OP_SUB  = 4'h2,
        OP_SUBU = 4'h3,
        OP_AND  = 4'h4,
        OP_OR   = 4'h5,
        OP_XOR  = 4'h6,
        OP_NOR  = 4'h7,
        OP_SLT  = 4'hA,
        OP_SLTU = 4'hB
    } alu_op_e;

    typedef enum logic [2:0] {
        SEL_SUM,
        SEL_LOGIC,
        SEL_SLT,
        SEL_SLTU,
        SEL_NONE
    } res_sel_e;

endpackage

// File: rtl/alu_opdec.sv
module alu_opdec
    import int_alu_pkg::*;
(
    input  logic [3:0] op_code,
    output logic       sub_mode,
    output logic       ovf_en,
    output res_sel_e   res_sel
);
    always_comb begin
        sub_mode = 1'b0;
        ovf_en   = 1'b0;
        res_sel  = SEL_NONE;
        unique case (op_code)
            OP_ADD:  begin res_sel = SEL_SUM; ovf_en = 1'b1; end
            OP_ADDU: begin res_sel = SEL_SUM; end
            OP_SUB:  begin res_sel = SEL_SUM; sub_mode = 1'b1; ovf_en = 1'b1; end
            OP_SUBU: begin res_sel = SEL_SUM; sub_mode = 1'b1; end
            OP_AND, OP_OR, OP_XOR, OP_NOR: res_sel = SEL_LOGIC;
            OP_SLT:  begin res_sel = SEL_SLT;  sub_mode = 1'b1; end
            OP_SLTU: begin res_sel = SEL_SLTU; sub_mode = 1'b1; end
            default: res_sel = SEL_NONE;
        endcase
    end
endmodule

// File: rtl/alu_addsub.sv
module alu_addsub #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sub_mode,
    output logic [W-1:0] sum,
    output logic         carry_top,
    output logic         carry_msb_in
);
    logic [W:0]   c;
    logic [W-1:0] bx;

    assign c[0] = sub_mode;
    assign bx   = b ^ {W{sub_mode}};

    for (genvar i = 0; i < W; i++) begin : g_cell
        assign sum[i]   = a[i] ^ bx[i] ^ c[i];
        assign c[i+1]   = (a[i] & bx[i]) | (a[i] & c[i]) | (bx[i] & c[i]);
    end

    assign carry_top    = c[W];
    assign carry_msb_in = c[W-1];
endmodule

// File: rtl/alu_bitwise.sv
module alu_bitwise #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [1:0]   fn,
    output logic [W-1:0] y
);
    always_comb begin
        unique case (fn)
            2'd0:    y = a & b;
            2'd1:    y = a | b;
            2'd2:    y = a ^ b;
            default: y = ~(a | b);
        endcase
    end
endmodule

// File: rtl/alu_resmux.sv
module alu_resmux
    import int_alu_pkg::*;
#(
    parameter int W = 32
) (
    input  res_sel_e     res_sel,
    input  logic [W-1:0] sum,
    input  logic [W-1:0] logic_y,
    input  logic         lt_signed,
    input  logic         lt_unsigned,
    output logic [W-1:0] result,
    output logic         zero
);
    localparam int PADW = W - 1;

    always_comb begin
        unique case (res_sel)
            SEL_SUM:   result = sum;
            SEL_LOGIC: result = logic_y;
            SEL_SLT:   result = {{PADW{1'b0}}, lt_signed};
            SEL_SLTU:  result = {{PADW{1'b0}}, lt_unsigned};
            default:   result = '0;
        endcase
    end

    assign zero = ~|result;
endmodule

// File: rtl/int_alu.sv
module int_alu
    import int_alu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [3:0]   op_code,
    input  logic [W-1:0] opnd_a,
    input  logic [W-1:0] opnd_b,
    output logic [W-1:0] res_out,
    output logic         flag_zero,
    output logic         flag_ovf
);
    logic         sub_mode;
    logic         ovf_en;
    res_sel_e     res_sel;
    logic [W-1:0] sum;
    logic         carry_top;
    logic         carry_msb_in;
    logic [W-1:0] logic_y;
    logic         ovf_raw;

    alu_opdec u_dec (
        .op_code (op_code),
        .sub_mode(sub_mode),
        .ovf_en  (ovf_en),
        .res_sel (res_sel)
    );

    alu_addsub #(.W(W)) u_add (
        .a           (opnd_a),
        .b           (opnd_b),
        .sub_mode    (sub_mode),
        .sum         (sum),
        .carry_top   (carry_top),
        .carry_msb_in(carry_msb_in)
    );

    alu_bitwise #(.W(W)) u_log (
        .a (opnd_a),
        .b (opnd_b),
        .fn(op_code[1:0]),
        .y (logic_y)
    );

    // signed overflow: carry into top bit differs from carry out of it
    assign ovf_raw  = carry_top ^ carry_msb_in;
    assign flag_ovf = ovf_en & ovf_raw;

    alu_resmux #(.W(W)) u_mux (
        .res_sel    (res_sel),
        .sum        (sum),
        .logic_y    (logic_y),
        .lt_signed  (sum[W-1] ^ ovf_raw),
        .lt_unsigned(~carry_top),
        .result     (res_out),
        .zero       (flag_zero)
    );
endmodule

// File: rtl/int_alu_chk.sv
module int_alu_chk #(
    parameter int W = 32
) (
    input logic [3:0]   op_code,
    input logic [W-1:0] opnd_a,
    input logic [W-1:0] opnd_b,
    input logic [W-1:0] res_out,
    input logic         flag_zero,
    input logic         flag_ovf
);
    logic unused_op;
    assign unused_op = (op_code == 4'h8) || (op_code == 4'h9) || (op_code >= 4'hC);

    always_comb begin
        if (op_code == 4'h1) begin
            AST_ADDU_SUM: assert (res_out == opnd_a + opnd_b) else $error("addu sum"); // R1
        end
        if (op_code == 4'h3) begin
            AST_SUBU_DIFF: assert (res_out == opnd_a - opnd_b) else $error("subu diff"); // R2
        end
        if (op_code != 4'h0 && op_code != 4'h2) begin
            AST_NO_OVERFLOW: assert (!flag_ovf) else $error("ovf on non-signed code"); // R5
        end
        if (op_code == 4'hA) begin
            AST_SLT_UPPER: assert (res_out[W-1:1] == '0) else $error("slt upper bits"); // R6
        end
        if (op_code == 4'hB) begin
            AST_SLTU_CMP: assert (res_out[0] == (opnd_a < opnd_b)) else $error("sltu cmp"); // R7
        end
        if (op_code == 4'h2) begin
            AST_EQ_BY_ZERO: assert (flag_zero == (opnd_a == opnd_b)) else $error("eq by zero"); // R8
        end
        if (unused_op) begin
            AST_UNUSED_QUIET: assert (res_out == '0 && flag_zero && !flag_ovf) else $error("unused code"); // R9
        end
    end
endmodule

bind int_alu int_alu_chk #(.W(W)) u_chk (
    .op_code  (op_code),
    .opnd_a   (opnd_a),
    .opnd_b   (opnd_b),
    .res_out  (res_out),
    .flag_zero(flag_zero),
    .flag_ovf (flag_ovf)
);

// File: tb/int_alu_tb_top.sv
`timescale 1ns/1ps
module int_alu_tb_top;
    localparam int W = 32;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [3:0]   op_code = 4'h0;
    logic [W-1:0] opnd_a = '0;
    logic [W-1:0] opnd_b = '0;
    logic [W-1:0] res_out;
    logic         flag_zero;
    logic         flag_ovf;

    int n_vec  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    int_alu #(.W(W)) dut_i (
        .op_code  (op_code),
        .opnd_a   (opnd_a),
        .opnd_b   (opnd_b),
        .res_out  (res_out),
        .flag_zero(flag_zero),
        .flag_ovf (flag_ovf)
    );

    function automatic string req_of(input logic [3:0] op);
        case (op)
            4'h0, 4'h1: return "R1";
            4'h2, 4'h3: return "R2";
            4'h4, 4'h5, 4'h6, 4'h7: return "R3";
            4'hA: return "R6";
            4'hB: return "R7";
            default: return "R9";
        endcase
    endfunction

    task automatic model(input logic [3:0] op, input logic [W-1:0] a, input logic [W-1:0] b,
                         output logic [W-1:0] r, output logic z, output logic o);
        longint sa, sb, s;
        sa = longint'($signed(a));
        sb = longint'($signed(b));
        r = '0;
        o = 1'b0;
        case (op)
            4'h0, 4'h1: r = a + b;
            4'h2, 4'h3: r = a - b;
            4'h4: r = a & b;
            4'h5: r = a | b;
            4'h6: r = a ^ b;
            4'h7: r = ~(a | b);
            4'hA: r = (sa < sb) ? 1 : 0;
            4'hB: r = (a < b) ? 1 : 0;
            default: r = '0;
        endcase
        if (op == 4'h0 || op == 4'h2) begin
            s = (op == 4'h0) ? sa + sb : sa - sb;
            o = (s > 64'sd2147483647) || (s < -64'sd2147483648);
        end
        z = (r == '0);
    endtask

    task automatic apply(input logic [3:0] op, input logic [W-1:0] a, input logic [W-1:0] b);
        logic [W-1:0] er;
        logic ez, eo;
        @(posedge clk);
        op_code <= op;
        opnd_a  <= a;
        opnd_b  <= b;
        @(negedge clk);
        model(op, a, b, er, ez, eo);
        n_vec++;
        if (res_out !== er) begin
            n_fail++;
            $display("FAIL %s op=%h a=%h b=%h result actual=%h expected=%h", req_of(op), op, a, b, res_out, er);
        end
        if (flag_zero !== ez) begin
            n_fail++;
            $display("FAIL R8 op=%h a=%h b=%h zero actual=%b expected=%b", op, a, b, flag_zero, ez);
        end
        if (flag_ovf !== eo) begin
            n_fail++;
            $display("FAIL %s op=%h a=%h b=%h ovf actual=%b expected=%b",
                     (op == 4'h0 || op == 4'h2) ? "R4" : "R5", op, a, b, flag_ovf, eo);
        end
    endtask

    logic [W-1:0] corners [8] = '{32'h0, 32'h1, 32'hFFFF_FFFF, 32'h7FFF_FFFF,
                                  32'h8000_0000, 32'h8000_0001, 32'h7FFF_FFFE, 32'h5555_AAAA};

    initial begin
        repeat (3) @(posedge clk);
        rst = 1'b0;
        // reset-state check: all-zero inputs, add code -> zero result (R1, R8)
        apply(4'h0, '0, '0);
        // corner sweep of every code, incl. unused (R1-R9 by tag via req_of)
        for (int op = 0; op < 16; op++)
            for (int i = 0; i < 8; i++)
                for (int j = 0; j < 8; j++)
                    apply(4'(op), corners[i], corners[j]);
        // equality via subtract: R8
        apply(4'h2, 32'h1234_5678, 32'h1234_5678);
        // signed compare across overflow: R6
        apply(4'hA, 32'h8000_0000, 32'h0000_0001);
        apply(4'hA, 32'h7FFF_FFFF, 32'hFFFF_FFFF);
        // unsigned compare: R7
        apply(4'hB, 32'h0000_0001, 32'hFFFF_FFFF);
        // random operands over all codes
        for (int k = 0; k < 4000; k++)
            apply(4'($urandom_range(0, 15)), $urandom, (k % 7 == 0) ? opnd_a : $urandom);
        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < 150000; c++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
        end
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end
endmodule